// File: doc/BRIEF.md
# Masked Checksum Pattern-Match Filter

This block sits on the receive path of an Ethernet controller and watches each incoming frame as a stream of bytes. The stream runs from the first destination-address byte through the frame check sequence. A 64-byte window is placed at a programmable distance from the start of the frame. A 64-bit mask picks which window bytes take part. The block sums the picked bytes as 16-bit words using ones' complement arithmetic. When the frame ends, it compares the complemented sum with a programmed expected value and reports pass or fail for that frame.

Bytes that the mask leaves out are removed from the sequence rather than replaced with zero, so every later byte moves up one place in the word pairing. A frame that ends before the whole window has arrived is rejected, whatever the mask holds. The offset, mask and expected value are taken when a frame starts, so software may reprogram them while a frame is still arriving.

Top module: `pm_filter`

## Requirements
- R1: Byte 0 of a frame is the byte presented with `in_sof`. The window covers frame bytes `cfg_offset` through `cfg_offset + 63`.
- R2: Mask bit i (bit 0 is the LSB of `cfg_mask`) decides whether window byte i, which is frame byte `cfg_offset + i`, takes part in the checksum.
- R3: A masked-out byte is removed from the sequence, not treated as zero. The next kept byte takes its place in the high/low word pairing.
- R4: Kept bytes are paired in arrival order, with the first byte of each pair as the high byte. Words are added with end-around carry, and the checksum is the bitwise inverse of that sum. With no kept bytes the checksum is 0xFFFF.
- R5: When the number of kept bytes is odd, the last word is formed with 0x00 as its low byte.
- R6: A frame whose length, counting the last byte presented with `in_eof`, is less than `cfg_offset + 64` fails. This holds even when the mask is all zero.
- R7: A frame that contains the whole window passes exactly when its checksum equals `cfg_csum`.
- R8: `res_valid` is high for exactly one cycle, on the clock after a frame's last byte is accepted, and at no other time. `res_match` is high only together with `res_valid`.
- R9: `cfg_offset`, `cfg_mask` and `cfg_csum` are sampled with the start-of-frame byte. Changes made later in the same frame have no effect on that frame's verdict.
- R10: Cycles with `in_valid` low are skipped without affecting the result. Valid bytes that arrive outside a frame (after its last byte and before the next `in_sof`) are ignored and produce no result.
- R11: While reset is asserted, and after its release until a frame ends, `res_valid` and `res_match` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_sof | input | 1 | The present byte is frame byte 0 |
| in_eof | input | 1 | The present byte is the frame's last byte |
| in_byte | input | 8 | Received frame byte |
| cfg_offset | input | OFF_W (16) | Window start, counted from frame byte 0 |
| cfg_mask | input | WIN_BYTES (64) | Per-byte include mask for the window |
| cfg_csum | input | 16 | Expected checksum |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_match | output | 1 | The frame passed the filter |

## Verification
The bench builds the block with its default 64-byte window and 16-bit offset, so both worked examples can be replayed byte for byte. These are the example with an odd byte count, a gap in the mask and a 0x563F result, and the source-address selection that gives 0x5BFC under two different offset and mask pairs. With the full 16-bit offset, windows that start hundreds of bytes into a frame can be tested. Frames that end one byte before and exactly at the window's last byte test the length rule at its boundary. A 64-byte all-0xFF window with every mask bit set exercises the end-around carry on every word.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // ones' complement 16-bit addition with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

endpackage

// File: rtl/pm_win_locate.sv
module pm_win_locate #(
    parameter int WIN_BYTES = 64,
    parameter int IDX_W     = 17,
    localparam int REL_W    = $clog2(WIN_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] start,
    output logic             in_win,
    output logic             last,
    output logic [REL_W-1:0] rel
);
    logic [IDX_W-1:0] diff;

    always_comb begin
        diff   = idx - start;
        in_win = (idx >= start) && (diff < IDX_W'(WIN_BYTES));
        last   = in_win && (diff == IDX_W'(WIN_BYTES - 1));
        rel    = diff[REL_W-1:0];
    end
endmodule

// File: rtl/pm_csum_step.sv
module pm_csum_step
    import pm_pkg::*;
(
    input  logic [15:0] sum_i,
    input  logic [7:0]  hi_i,
    input  logic        odd_i,
    input  logic        keep,
    input  logic [7:0]  data,
    output logic [15:0] sum_o,
    output logic [7:0]  hi_o,
    output logic        odd_o,
    output logic [15:0] csum_o
);
    always_comb begin
        sum_o = sum_i;
        hi_o  = hi_i;
        odd_o = odd_i;
        if (keep) begin
            if (odd_i) begin
                sum_o = oc_add(sum_i, {hi_i, data});
                odd_o = 1'b0;
            end else begin
                hi_o  = data;
                odd_o = 1'b1;
            end
        end
        // a pending high byte is closed with a zero low byte
        csum_o = odd_o ? ~oc_add(sum_o, {hi_o, 8'h00}) : ~sum_o;
    end
endmodule

// File: rtl/pm_filter.sv
module pm_filter #(
    parameter int WIN_BYTES = 64,
    parameter int OFF_W     = 16,
    localparam int IDX_W    = OFF_W + 1,
    localparam int REL_W    = $clog2(WIN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_byte,
    input  logic [OFF_W-1:0]     cfg_offset,
    input  logic [WIN_BYTES-1:0] cfg_mask,
    input  logic [15:0]          cfg_csum,
    output logic                 res_valid,
    output logic                 res_match
);
    typedef struct packed {
        logic                 active;
        logic [IDX_W-1:0]     idx;
        logic [OFF_W-1:0]     off;
        logic [WIN_BYTES-1:0] mask;
        logic [15:0]          expv;
        logic [15:0]          sum;
        logic [7:0]           hi;
        logic                 odd;
        logic                 done;
        logic                 rvalid;
        logic                 rmatch;
    } st_t;

    st_t st_d, st_q;

    logic                 take;
    logic [IDX_W-1:0]     cur_idx;
    logic [OFF_W-1:0]     cur_off;
    logic [WIN_BYTES-1:0] cur_mask;
    logic [15:0]          cur_exp;
    logic [15:0]          base_sum;
    logic [7:0]           base_hi;
    logic                 base_odd;
    logic                 base_done;
    logic                 in_win;
    logic                 win_last;
    logic [REL_W-1:0]     rel;
    logic                 keep;
    logic [15:0]          sum_n;
    logic [7:0]           hi_n;
    logic                 odd_n;
    logic [15:0]          csum_n;

    // configuration and accumulator start fresh on the start-of-frame byte
    always_comb begin
        take      = in_valid && (in_sof || st_q.active);
        cur_idx   = in_sof ? '0 : st_q.idx;
        cur_off   = in_sof ? cfg_offset : st_q.off;
        cur_mask  = in_sof ? cfg_mask : st_q.mask;
        cur_exp   = in_sof ? cfg_csum : st_q.expv;
        base_sum  = in_sof ? '0 : st_q.sum;
        base_hi   = in_sof ? '0 : st_q.hi;
        base_odd  = in_sof ? 1'b0 : st_q.odd;
        base_done = in_sof ? 1'b0 : st_q.done;
        keep      = take && in_win && cur_mask[rel];
    end

    pm_win_locate #(
        .WIN_BYTES(WIN_BYTES),
        .IDX_W    (IDX_W)
    ) u_locate (
        .idx   (cur_idx),
        .start ({1'b0, cur_off}),
        .in_win(in_win),
        .last  (win_last),
        .rel   (rel)
    );

    pm_csum_step u_step (
        .sum_i (base_sum),
        .hi_i  (base_hi),
        .odd_i (base_odd),
        .keep  (keep),
        .data  (in_byte),
        .sum_o (sum_n),
        .hi_o  (hi_n),
        .odd_o (odd_n),
        .csum_o(csum_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rmatch = 1'b0;
        if (take) begin
            st_d.active = !in_eof;
            st_d.idx    = (&cur_idx) ? cur_idx : cur_idx + 1'b1;
            st_d.off    = cur_off;
            st_d.mask   = cur_mask;
            st_d.expv   = cur_exp;
            st_d.sum    = sum_n;
            st_d.hi     = hi_n;
            st_d.odd    = odd_n;
            st_d.done   = base_done || win_last;
            if (in_eof) begin
                st_d.rvalid = 1'b1;
                st_d.rmatch = (base_done || win_last) && (csum_n == cur_exp);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.rvalid;
    assign res_match = st_q.rmatch;
endmodule

// File: rtl/pm_filter_chk.sv
module pm_filter_chk #(
    parameter int WIN_BYTES = 64,
    parameter int OFF_W     = 16,
    localparam int CNT_W    = OFF_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic [OFF_W-1:0] cfg_offset,
    input logic             res_valid,
    input logic             res_match
);
    logic             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OFF_W-1:0] off_q;
    logic             end_q;
    logic             short_q;
    logic             acc;
    logic [CNT_W-1:0] cnt_c;
    logic [CNT_W-1:0] need_c;

    always_comb begin
        acc    = in_valid && (in_sof || act_q);
        cnt_c  = in_sof ? CNT_W'(1) : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
        need_c = CNT_W'(in_sof ? cfg_offset : off_q) + CNT_W'(WIN_BYTES);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            cnt_q   <= '0;
            off_q   <= '0;
            end_q   <= 1'b0;
            short_q <= 1'b0;
        end else begin
            end_q   <= acc && in_eof;
            short_q <= acc && in_eof && (cnt_c < need_c);
            if (acc) begin
                act_q <= !in_eof;
                cnt_q <= cnt_c;
                if (in_sof) off_q <= cfg_offset;
            end
        end
    end

    // R8: strobe exactly one clock after an accepted last byte
    a_r8_strobe_timing: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == end_q);

    // R8: match only with the strobe
    a_r8_match_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_match |-> res_valid);

    // R6: window not fully received means fail
    a_r6_short_frame_fails: assert property (@(posedge clk) disable iff (!rst_n)
        short_q |-> !res_match);

    // R6: a one-byte frame can never hold the window
    a_r6_single_byte_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_eof) |=> !res_match);

    // R11: nothing reported on the first cycle out of reset
    a_r11_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !res_valid && !res_match);
endmodule

bind pm_filter pm_filter_chk #(
    .WIN_BYTES(WIN_BYTES),
    .OFF_W    (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .cfg_offset(cfg_offset),
    .res_valid (res_valid),
    .res_match (res_match)
);

// File: tb/pm_filter_bench.sv
module pm_filter_bench;
    localparam int WIN = 64;
    localparam int OW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_sof = 1'b0;
    logic           in_eof = 1'b0;
    logic [7:0]     in_byte = '0;
    logic [OW-1:0]  cfg_offset = '0;
    logic [WIN-1:0] cfg_mask = '0;
    logic [15:0]    cfg_csum = '0;
    logic           res_valid;
    logic           res_match;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit    exp_q[$];
    string tag_q[$];
    logic [7:0] fr[$];

    always #2 clk = ~clk;

    pm_filter #(.WIN_BYTES(WIN), .OFF_W(OW)) u_pm_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .cfg_offset(cfg_offset),
        .cfg_mask(cfg_mask), .cfg_csum(cfg_csum),
        .res_valid(res_valid), .res_match(res_match)
    );

    function automatic logic [15:0] ocadd(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

    // reference checksum from the requirements
    function automatic logic [15:0] csum_of(input int off, input logic [WIN-1:0] m);
        logic [7:0]  kept[$];
        logic [15:0] s = 16'h0;
        for (int i = 0; i < WIN; i++)
            if (m[i] && (off + i) < fr.size()) kept.push_back(fr[off + i]);
        if (kept.size() % 2 == 1) kept.push_back(8'h00);
        for (int i = 0; i < kept.size(); i += 2) s = ocadd(s, {kept[i], kept[i+1]});
        return ~s;
    endfunction

    function automatic bit model(input int off, input logic [WIN-1:0] m, input logic [15:0] ex);
        if (fr.size() < off + WIN) return 1'b0;
        return csum_of(off, m) == ex;
    endfunction

    task automatic check(input string tag, input logic act, input logic ex);
        n_chk++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, ex);
        end
    endtask

    task automatic mk_frame(input int len, input int seed);
        fr.delete();
        for (int i = 0; i < len; i++) fr.push_back(8'((i * 37 + seed * 11 + 5) & 8'hFF));
    endtask

    // driver: pushes the expected verdict, then streams the frame
    task automatic send(input string tag, input int off, input logic [WIN-1:0] m,
                        input logic [15:0] ex, input int gap, input bit scramble);
        exp_q.push_back(model(off, m, ex));
        tag_q.push_back(tag);
        for (int i = 0; i < fr.size(); i++) begin
            if (gap > 0 && i % gap == 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_byte = 8'hA5;
            end
            @(negedge clk);
            if (i == 0) begin
                cfg_offset = OW'(off); cfg_mask = m; cfg_csum = ex;
            end else if (scramble) begin
                cfg_offset = OW'(i * 3); cfg_mask = ~m; cfg_csum = ex ^ 16'h1234;
            end
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == fr.size() - 1);
            in_byte = fr[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected verdict", res_valid, 1'b0);
            end else begin
                check(tag_q.pop_front(), res_match, exp_q.pop_front());
            end
        end else if (rst_n && res_match) begin
            check("R8 match without valid", res_match, 1'b0);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset valid", res_valid, 1'b0);
        check("R11 reset match", res_match, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle valid", res_valid, 1'b0);

        // R1 R2 R3 R5: worked example, gap in mask, odd count
        mk_frame(80, 1);
        fr[0]=8'h11; fr[1]=8'h22; fr[2]=8'h33; fr[3]=8'h44; fr[4]=8'h55; fr[5]=8'h66;
        fr[6]=8'h77; fr[7]=8'h88; fr[8]=8'h99; fr[9]=8'hAA; fr[10]=8'hBB; fr[11]=8'hCC;
        fr[12]=8'h00; fr[13]=8'h5A; fr[14]=8'h09; fr[15]=8'h0A; fr[16]=8'h0B;
        fr[17]=8'h0C; fr[18]=8'h0D;
        send("R3 example 563F pass", 6, 64'h0000_0000_0000_1F0A, 16'h563F, 0, 0);
        send("R7 example wrong value fails", 6, 64'h0000_0000_0000_1F0A, 16'h563E, 0, 0);

        // R4: source address via two offset/mask pairs
        mk_frame(64, 2);
        fr[6]=8'h00; fr[7]=8'h04; fr[8]=8'hA3; fr[9]=8'hFF; fr[10]=8'hFF; fr[11]=8'hFF;
        send("R4 offset 0 bits 6-11 window ends at last byte", 0, 64'hFC0, 16'h5BFC, 0, 0);
        send("R6 offset 6 len 64 short", 6, 64'h3F, 16'h5BFC, 0, 0);
        mk_frame(70, 2);
        fr[6]=8'h00; fr[7]=8'h04; fr[8]=8'hA3; fr[9]=8'hFF; fr[10]=8'hFF; fr[11]=8'hFF;
        send("R1 offset 6 bits 0-5 len 70 pass", 6, 64'h3F, 16'h5BFC, 0, 0);
        void'(fr.pop_back());
        send("R6 offset 6 len 69 fails", 6, 64'h3F, 16'h5BFC, 0, 0);

        // R6: empty mask
        mk_frame(100, 3);
        send("R4 empty mask checksum FFFF", 0, 64'h0, 16'hFFFF, 0, 0);
        mk_frame(63, 3);
        send("R6 empty mask short frame fails", 0, 64'h0, 16'hFFFF, 0, 0);

        // R5: three kept bytes
        mk_frame(64, 4);
        fr[0]=8'h12; fr[1]=8'h34; fr[2]=8'h56;
        send("R5 odd pad 97CB", 0, 64'h7, 16'h97CB, 0, 0);

        // R4: end-around carry on all-ones data
        mk_frame(64, 5);
        for (int i = 0; i < 64; i++) fr[i] = 8'hFF;
        send("R4 all FF window gives 0000", 0, '1, 16'h0000, 0, 0);

        // R2 R3: scattered mask, reference value
        mk_frame(90, 6);
        send("R2 scattered mask pass", 10, 64'hF0F0_1234_8001_ABCD,
             csum_of(10, 64'hF0F0_1234_8001_ABCD), 0, 0);
        send("R3 shift-sensitive mask pass", 3, 64'h5555_5555_AAAA_AAAB,
             csum_of(3, 64'h5555_5555_AAAA_AAAB), 0, 0);

        // R10: idle cycles inside the frame
        send("R10 gapped stream pass", 10, 64'hF0F0_1234_8001_ABCD,
             csum_of(10, 64'hF0F0_1234_8001_ABCD), 3, 0);
        send("R10 gapped stream wrong value", 10, 64'hF0F0_1234_8001_ABCD,
             ~csum_of(10, 64'hF0F0_1234_8001_ABCD), 2, 0);

        // R9: configuration changed during the frame
        send("R9 config change mid-frame ignored", 10, 64'hF0F0_1234_8001_ABCD,
             csum_of(10, 64'hF0F0_1234_8001_ABCD), 0, 1);

        // R1: large offset, boundary
        mk_frame(264, 7);
        send("R1 offset 200 len 264 pass", 200, 64'hDEAD_BEEF_0BAD_F00D,
             csum_of(200, 64'hDEAD_BEEF_0BAD_F00D), 0, 0);
        void'(fr.pop_back());
        send("R6 offset 200 len 263 fails", 200, 64'hDEAD_BEEF_0BAD_F00D,
             csum_of(200, 64'hDEAD_BEEF_0BAD_F00D), 0, 0);

        // R6: one-byte frame
        mk_frame(1, 8);
        send("R6 single byte frame fails", 0, 64'h0, 16'hFFFF, 0, 0);

        // R10: bytes outside any frame produce nothing
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 4); in_byte = 8'(i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        check("R10 no verdict for stray bytes", res_valid, 1'b0);
        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: got %0d pending verdicts expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule